// File: doc/BRIEF.md
# Pulse-Swallow Programmable Feedback Divider

This block divides its input clock by a programmable ratio of 64·N + A. It does this the way a pulse-swallow synthesizer does: a dual-modulus stage counts either 65 or 64 input clocks per prescaler cycle, a swallow counter keeps the stage at 65 for the first A prescaler cycles of a period, and a main counter ends the period after N prescaler cycles. The block drives the modulus-control line that such a stage needs and gives one single-clock pulse per division period.

New A and N values arrive on a load strobe. A legal setting (N at least 5, A below N) is parked and takes over only when the running period ends, so a period is never cut short or stretched by a write. An illegal setting is refused: the running ratio stays, and an error flag is raised until the next legal write.

Top module: `swallow_divider`

## Requirements
- R1: For a legal active setting the distance between two consecutive `div_pulse` assertions is exactly 64·N + A input clocks.
- R2: `div_pulse` is high for exactly one input clock, the last clock of each period.
- R3: `mod_sel` (1 = divide by 65, 0 = divide by 64) is high for the first 65·A input clocks of each period and low for the remaining 64·(N−A) clocks.
- R4: The prescaler count never exceeds 64; a prescaler cycle lasts 65 clocks while `mod_sel` is high and 64 while it is low.
- R5: A load with `main_in` below 5 or `swallow_in` not less than `main_in` sets `cfg_err` in the next cycle; `cfg_err` stays set until a legal load clears it.
- R6: A refused load leaves the active ratio and any parked setting unchanged.
- R7: A legal load takes effect at the start of the next period; the period that is running keeps its old length.
- R8: Synchronous reset clears both counters, discards any parked setting, activates the default N = 8, A = 3 and starts a fresh period with `mod_sel` high, `div_pulse` low and `cfg_err` low.
- R9: The edge settings A = 0 (no 65-clock cycles), N = 5 with A = 4, and N = 64 with A = 63 divide correctly.
- R10: When several legal loads arrive within one period, the last one is the one applied at the next period start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock being divided |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Strobe capturing `swallow_in` and `main_in` |
| swallow_in | input | 6 | Requested swallow count A |
| main_in | input | 12 | Requested main count N |
| mod_sel | output | 1 | Modulus control, 1 selects divide by 65 |
| div_pulse | output | 1 | One-clock pulse on the last clock of each period |
| cfg_err | output | 1 | Set by a refused load, cleared by a legal load |

## Verification
The hardest case to reach is a write that lands in the middle of a period, or on its very last clock, while another setting is already parked, because the outcome depends on how the boundary and the write are ordered. The stimulus synchronises to a pulse, waits a chosen number of clocks, then writes once or twice, and measures both the cut-off period and the next one; a reset is also issued while a setting is parked. A behavioural model that tracks only the position inside the period is compared with all three outputs on every clock.

// File: rtl/swdiv_pkg.sv
package swdiv_pkg;

  // Total input clocks in one division period.
  function automatic int unsigned swdiv_ratio(input int unsigned pre_lo,
                                              input int unsigned n,
                                              input int unsigned a);
    return pre_lo * n + a;
  endfunction

  // Legality of a requested setting: main count large enough and above swallow.
  function automatic logic swdiv_cfg_ok(input int unsigned n,
                                        input int unsigned a,
                                        input int unsigned n_min);
    return (n >= n_min) && (a < n);
  endfunction

endpackage

// File: rtl/swdiv_prescaler.sv
module swdiv_prescaler #(
  parameter int PRE_LO = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic mod_hi,
  output logic pre_tick
);
  localparam int CW = $clog2(PRE_LO + 1);

  logic [CW-1:0] pre_cnt;
  logic [CW-1:0] pre_last;

  assign pre_last = mod_hi ? CW'(PRE_LO) : CW'(PRE_LO - 1);
  assign pre_tick = (pre_cnt == pre_last);

  always_ff @(posedge clk) begin
    if (rst)           pre_cnt <= '0;
    else if (pre_tick) pre_cnt <= '0;
    else               pre_cnt <= pre_cnt + 1'b1;
  end

  assert_pre_range_R4: assert property (@(posedge clk) disable iff (rst)
    pre_cnt <= CW'(PRE_LO));

  assert_pre_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    pre_tick |=> (pre_cnt == '0));

endmodule

// File: rtl/swdiv_seq.sv
module swdiv_seq #(
  parameter int A_W = 6,
  parameter int N_W = 12
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           pre_tick,
  input  logic [A_W-1:0] act_a,
  input  logic [N_W-1:0] act_n,
  output logic           mod_hi,
  output logic           period_end
);
  logic [A_W-1:0] sw_cnt;
  logic [N_W-1:0] main_cnt;
  logic           main_last;

  assign mod_hi     = (sw_cnt < act_a);
  assign main_last  = (main_cnt == act_n - 1'b1);
  assign period_end = pre_tick && main_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_cnt   <= '0;
      main_cnt <= '0;
    end else if (period_end) begin
      sw_cnt   <= '0;
      main_cnt <= '0;
    end else if (pre_tick) begin
      main_cnt <= main_cnt + 1'b1;
      if (mod_hi) sw_cnt <= sw_cnt + 1'b1;
    end
  end

  assert_pulse_single_R2: assert property (@(posedge clk) disable iff (rst)
    period_end |=> !period_end);

  assert_mod_steady_R3: assert property (@(posedge clk) disable iff (rst)
    !pre_tick |=> $stable(mod_hi));

  assert_swallow_bound_R3: assert property (@(posedge clk) disable iff (rst)
    sw_cnt <= act_a);

  assert_main_bound_R1: assert property (@(posedge clk) disable iff (rst)
    main_cnt < act_n);

endmodule

// File: rtl/swdiv_cfg.sv
module swdiv_cfg
  import swdiv_pkg::*;
#(
  parameter int A_W   = 6,
  parameter int N_W   = 12,
  parameter int N_MIN = 5,
  parameter int DEF_A = 3,
  parameter int DEF_N = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [A_W-1:0] a_in,
  input  logic [N_W-1:0] n_in,
  input  logic           period_end,
  output logic [A_W-1:0] act_a,
  output logic [N_W-1:0] act_n,
  output logic           cfg_err
);
  logic [A_W-1:0] pend_a;
  logic [N_W-1:0] pend_n;
  logic           pend_v;
  logic           in_ok;
  logic           load_ok;
  logic           load_bad;

  assign in_ok    = swdiv_cfg_ok(32'(n_in), 32'(a_in), N_MIN);
  assign load_ok  = load && in_ok;
  assign load_bad = load && !in_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_a   <= A_W'(DEF_A);
      act_n   <= N_W'(DEF_N);
      pend_a  <= A_W'(DEF_A);
      pend_n  <= N_W'(DEF_N);
      pend_v  <= 1'b0;
      cfg_err <= 1'b0;
    end else begin
      if (period_end && pend_v) begin
        act_a <= pend_a;
        act_n <= pend_n;
      end
      if (load_ok) begin
        pend_a  <= a_in;
        pend_n  <= n_in;
        pend_v  <= 1'b1;
        cfg_err <= 1'b0;
      end else begin
        if (period_end) pend_v  <= 1'b0;
        if (load_bad)   cfg_err <= 1'b1;
      end
    end
  end

  assert_bad_load_flag_R5: assert property (@(posedge clk) disable iff (rst)
    load_bad |=> cfg_err);

  assert_good_load_clear_R5: assert property (@(posedge clk) disable iff (rst)
    load_ok |=> !cfg_err);

  assert_act_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !period_end |=> ($stable(act_a) && $stable(act_n)));

  assert_bad_load_no_park_R6: assert property (@(posedge clk) disable iff (rst)
    (load_bad && !period_end) |=> ($stable(pend_a) && $stable(pend_n) && $stable(pend_v)));

  assert_act_legal_R6: assert property (@(posedge clk) disable iff (rst)
    (act_n >= N_W'(N_MIN)) && ({{(N_W-A_W){1'b0}}, act_a} < act_n));

endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
  import swdiv_pkg::*;
#(
  parameter int PRE_LO = 64,
  parameter int A_W    = 6,
  parameter int N_W    = 12,
  parameter int N_MIN  = 5,
  parameter int DEF_A  = 3,
  parameter int DEF_N  = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [5:0]     swallow_in,
  input  logic [11:0]    main_in,
  output logic           mod_sel,
  output logic           div_pulse,
  output logic           cfg_err
);
  localparam int PER_W = N_W + $clog2(PRE_LO + 1) + 1;

  logic           pre_tick;
  logic           mod_hi;
  logic           period_end;
  logic [A_W-1:0] act_a;
  logic [N_W-1:0] act_n;

  swdiv_prescaler #(.PRE_LO(PRE_LO)) u_pre (
    .clk      (clk),
    .rst      (rst),
    .mod_hi   (mod_hi),
    .pre_tick (pre_tick)
  );

  swdiv_seq #(.A_W(A_W), .N_W(N_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .pre_tick   (pre_tick),
    .act_a      (act_a),
    .act_n      (act_n),
    .mod_hi     (mod_hi),
    .period_end (period_end)
  );

  swdiv_cfg #(
    .A_W(A_W), .N_W(N_W), .N_MIN(N_MIN), .DEF_A(DEF_A), .DEF_N(DEF_N)
  ) u_cfg (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .a_in       (A_W'(swallow_in)),
    .n_in       (N_W'(main_in)),
    .period_end (period_end),
    .act_a      (act_a),
    .act_n      (act_n),
    .cfg_err    (cfg_err)
  );

  assign mod_sel   = mod_hi;
  assign div_pulse = period_end;

  // Checker-only clock counter since the last period boundary.
  logic [PER_W-1:0] per_cnt;
  always_ff @(posedge clk) begin
    if (rst || div_pulse) per_cnt <= '0;
    else                  per_cnt <= per_cnt + 1'b1;
  end

  assert_period_len_R1: assert property (@(posedge clk) disable iff (rst)
    div_pulse |-> (32'(per_cnt) + 1 == swdiv_ratio(PRE_LO, 32'(act_n), 32'(act_a))));

  assert_reset_state_R8: assert property (@(posedge clk)
    rst |=> (mod_sel == (DEF_A > 0)) && !div_pulse && !cfg_err);

endmodule

// File: tb/swallow_divider_tb.sv
module swallow_divider_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load = 1'b0;
  logic [5:0]  a_in = '0;
  logic [11:0] n_in = '0;
  wire         mod_sel, div_pulse, cfg_err;

  always #5 clk = ~clk;

  swallow_divider dut_i (
    .clk(clk), .rst(rst), .load(load), .swallow_in(a_in), .main_in(n_in),
    .mod_sel(mod_sel), .div_pulse(div_pulse), .cfg_err(cfg_err)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit cmp_on = 0;

  // Behavioural model: position inside the period plus parked setting.
  int m_pos = 0, m_n = 8, m_a = 3, m_pn = 0, m_pa = 0, m_err = 0;
  bit m_pv = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_pos = 0; m_n = 8; m_a = 3; m_pv = 0; m_err = 0;
    end else begin
      bit last;
      last = (m_pos == 64 * m_n + m_a - 1);
      if (last) begin
        m_pos = 0;
        if (m_pv) begin m_n = m_pn; m_a = m_pa; end
      end else m_pos++;
      if (load && n_in >= 5 && a_in < n_in) begin
        m_pn = n_in; m_pa = a_in; m_pv = 1; m_err = 0;
      end else begin
        if (last) m_pv = 0;
        if (load) m_err = 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cmp_on && !rst) begin
      int e_mod, e_pul;
      e_mod = (m_pos < 65 * m_a) ? 1 : 0;
      e_pul = (m_pos == 64 * m_n + m_a - 1) ? 1 : 0;
      chk(mod_sel == e_mod, "R3 mod_sel per clock", mod_sel, e_mod);
      chk(div_pulse == e_pul, "R2 div_pulse per clock", div_pulse, e_pul);
      chk(cfg_err == m_err, "R5 cfg_err per clock", cfg_err, m_err);
    end
    if (cyc > 150000) begin
      chk(0, "R1 watchdog expired", cyc, 150000);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  task automatic do_load(input int n, input int a);
    @(negedge clk);
    load = 1; n_in = 12'(n); a_in = 6'(a);
    @(negedge clk);
    load = 0;
  endtask

  // Clocks until the next pulse (inclusive) and clocks with mod_sel high.
  task automatic wait_pulse(output int gap, output int highs);
    gap = 0; highs = 0;
    do begin
      @(negedge clk);
      gap++;
      if (mod_sel) highs++;
    end while (!div_pulse);
  endtask

  task automatic measure(input int n, input int a, input string tag);
    int g, h;
    wait_pulse(g, h);
    chk(g == 64 * n + a, {tag, " period"}, g, 64 * n + a);
    chk(h == 65 * a, "R3 clocks with mod_sel high", h, 65 * a);
  endtask

  initial begin
    int g, h;
    repeat (3) @(negedge clk);
    chk(mod_sel == 1, "R8 reset mod_sel", mod_sel, 1);
    chk(div_pulse == 0, "R8 reset div_pulse", div_pulse, 0);
    chk(cfg_err == 0, "R8 reset cfg_err", cfg_err, 0);
    cmp_on = 1;
    rst = 0;
    wait_pulse(g, h);
    chk(g == 514, "R8 first period after reset", g, 514);
    measure(8, 3, "R1 default");

    // A = 0 and the smallest legal N
    do_load(5, 0);
    wait_pulse(g, h);
    measure(5, 0, "R9 N=5 A=0");
    do_load(5, 4);
    wait_pulse(g, h);
    measure(5, 4, "R9 N=5 A=4");
    do_load(64, 63);
    wait_pulse(g, h);
    measure(64, 63, "R9 N=64 A=63");

    // Refused loads
    do_load(4, 0);
    chk(cfg_err == 1, "R5 error after N=4", cfg_err, 1);
    do_load(10, 10);
    chk(cfg_err == 1, "R5 error after A=N", cfg_err, 1);
    wait_pulse(g, h);
    measure(64, 63, "R6 ratio kept after refused load");

    // Mid-period legal load
    repeat (100) @(negedge clk);
    do_load(100, 0);
    chk(cfg_err == 0, "R5 error cleared by legal load", cfg_err, 0);
    wait_pulse(g, h);
    chk(102 + g == 4159, "R7 running period unchanged", 102 + g, 4159);
    measure(100, 0, "R7 new ratio");

    // Two loads in one period
    repeat (30) @(negedge clk);
    do_load(7, 2);
    do_load(4, 1);
    do_load(9, 1);
    wait_pulse(g, h);
    measure(9, 1, "R10 last load wins");

    // Reset with a parked setting
    do_load(20, 5);
    repeat (5) @(negedge clk);
    rst = 1;
    @(negedge clk);
    chk(mod_sel == 1, "R8 mod_sel after reset", mod_sel, 1);
    rst = 0;
    wait_pulse(g, h);
    chk(g == 514, "R8 parked setting dropped", g, 514);
    measure(8, 3, "R8 default after reset");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule